// File: doc/BRIEF.md
# Quadrature Position Counter with Frozen Two-Byte Readout

This block turns the two phase signals of an incremental encoder into a 16-bit position count. Each phase is first brought into the clock domain by a two-flop synchronizer. It then passes a digital filter that accepts a new level only after three equal samples. A decoder counts every valid edge on either phase as one step (4x decoding). The count goes up or down depending on which phase leads. If both filtered phases change in the same sample, no step is taken and a sticky error flag is raised.

A host reads the position through an 8-bit port, one byte at a time. When it starts a read, a snapshot register stops tracking the counter at the next falling clock edge. The high byte and the low byte therefore come from the same instant, even while the encoder keeps moving. The snapshot resumes tracking once the low byte has been read and the read strobe is released.

The counter can wrap in either direction. On a wrap the block raises a one-clock carry pulse and a direction flag, so an external counter can extend the range. The carry pulse comes in the same cycle as the wrapped count. A read started in that cycle therefore already holds the wrapped value, and an extension byte captured at read start stays consistent with it.

Top module: `quad_pos_counter`

## Requirements
- R1: A phase input level reaches the decoder only after the synchronized input has shown it for 3 consecutive clock samples. A pulse of 2 clock cycles or less on a phase input changes neither the count nor the error flag.
- R2: The phase pair {phase_a, phase_b} in the sequence 00, 10, 11, 01, 00 adds one to the count at each step. The reverse sequence subtracts one at each step. The count changes by at most one per clock.
- R3: A change of both filtered phases in the same sample leaves the count unchanged and sets decode_err. decode_err then stays high until reset.
- R4: A wrap from 0xFFFF to 0x0000 gives a one-clock carry_pulse with carry_up = 1. A wrap from 0x0000 to 0xFFFF gives a one-clock carry_pulse with carry_up = 0.
- R5: With lo_byte_sel = 0 and rd_en_n = 0, the snapshot stops updating at the next falling clock edge. It then holds its value while the counter keeps counting.
- R6: While rd_en_n = 0, data_valid = 1 and data_out carries the snapshot's bits 15:8 when lo_byte_sel = 0, or its bits 7:0 when lo_byte_sel = 1.
- R7: While rd_en_n = 1, data_out = 0 and data_valid = 0.
- R8: After the low byte has been read during a frozen snapshot, raising rd_en_n releases the snapshot, which tracks the counter again.
- R9: A synchronous reset (rst_n = 0 at a clock edge) clears the count, the snapshot, the freeze state, decode_err and carry_pulse.
- R10: carry_pulse is high in exactly the clock cycle in which the counter first holds the wrapped value. A read started in that cycle returns the wrapped count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; counter on rising edge, snapshot on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| lo_byte_sel | input | 1 | Byte select: 0 high byte, 1 low byte |
| rd_en_n | input | 1 | Active-low read strobe |
| data_out | output | 8 | Selected snapshot byte, zero when not reading |
| data_valid | output | 1 | High while data_out carries a snapshot byte |
| carry_pulse | output | 1 | One-clock pulse on counter wrap |
| carry_up | output | 1 | Wrap direction, 1 = up, valid with carry_pulse |
| decode_err | output | 1 | Sticky flag for a double-phase change |

## Verification
A wrong filter or decoder state shows up as a position that is off by one or more steps. That error is visible at the next two-byte read, about ten clocks after the offending edge. A snapshot that fails to freeze shows up as a high byte and a low byte taken from different counts. Reads that straddle a carry from 0x00FF to 0x0100 and a wrap from 0xFFFF expose this within one read cycle. A misplaced carry pulse is caught by starting a read in the pulse's own cycle: the value read must already be the wrapped one.

// File: rtl/qpc_pkg.sv
// Shared widths and phase helpers for the quadrature position counter.
// Assumes a position that is exactly two bytes wide.
package qpc_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned POS_W  = 2 * BYTE_W;

    typedef logic [POS_W-1:0] pos_t;

    // Maps a phase pair {a,b} onto its position in the 00,10,11,01 cycle.
    function automatic logic [1:0] ph_index(input logic [1:0] ab);
        return {ab[0], ab[1] ^ ab[0]};
    endfunction
endpackage

// File: rtl/qpc_input_filter.sv
// Synchronizes one asynchronous phase input and passes a new level only
// after it has been seen on FILT_HOLD consecutive clocks.
// Assumes SYNC_N >= 2 and FILT_HOLD >= 3.
module qpc_input_filter #(
    parameter int unsigned SYNC_N    = 2,
    parameter int unsigned FILT_HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int unsigned HIST_W = FILT_HOLD - 1;

    logic [SYNC_N-1:0] sync_q;
    logic [HIST_W-1:0] hist_q;
    logic              sampled;
    logic              agree;
    logic              clean_q;

    assign sampled = sync_q[SYNC_N-1];
    assign agree   = (&{hist_q, sampled}) | ~(|{hist_q, sampled});

    // Synchronizer chain into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], raw_in};
    end

    // History of past synchronized samples.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST_W-2:0], sampled};
    end

    // Accept the level once the whole window agrees.
    always_ff @(posedge clk) begin
        if (!rst_n)     clean_q <= 1'b0;
        else if (agree) clean_q <= sampled;
    end

    assign clean_out = clean_q;

    if (FILT_HOLD == 3) begin : g_chk
        AST_FILT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $changed(clean_q) |-> ($past(sampled, 1) == clean_q) && ($past(sampled, 2) == clean_q) && ($past(sampled, 3) == clean_q)); // R1
    end
endmodule

// File: rtl/qpc_quad_decode.sv
// Turns the filtered phase pair into single-step up/down requests with
// 4x decoding. A change of both phases at once is counted as an error.
// Assumes inputs are already synchronous and filtered.
module qpc_quad_decode
    import qpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    output logic step,
    output logic step_up,
    output logic err
);
    logic [1:0] prev_q;
    logic [1:0] now_ab;
    logic [1:0] diff;
    logic       bad;
    logic       err_q;

    assign now_ab  = {ph_a, ph_b};
    assign diff    = ph_index(now_ab) - ph_index(prev_q);
    assign step    = (diff == 2'd1) || (diff == 2'd3);
    assign step_up = (diff == 2'd1);
    assign bad     = (diff == 2'd2);

    // Remember the last filtered phase pair.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= now_ab;
    end

    // Sticky error on an illegal double transition.
    always_ff @(posedge clk) begin
        if (!rst_n)   err_q <= 1'b0;
        else if (bad) err_q <= 1'b1;
    end

    assign err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_q) |-> err_q); // R3
    AST_ERR_ON_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (now_ab == ~prev_q) |=> err_q); // R3
endmodule

// File: rtl/qpc_pos_counter.sv
// Up/down position counter with a registered wrap pulse. The pulse and
// the wrapped count become visible in the same clock cycle.
// Assumes at most one step request per clock.
module qpc_pos_counter
    import qpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic step_up,
    output pos_t pos,
    output logic carry,
    output logic carry_dir_up
);
    pos_t pos_q;
    logic carry_q;
    logic carry_up_q;
    logic wraps;

    assign wraps = step && (step_up ? (pos_q == '1) : (pos_q == '0));

    // Count one step up or down.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos_q <= '0;
        else if (step) pos_q <= step_up ? pos_q + POS_W'(1) : pos_q - POS_W'(1);
    end

    // Flag a wrap for one cycle, with its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q    <= 1'b0;
            carry_up_q <= 1'b0;
        end else begin
            carry_q <= wraps;
            if (step) carry_up_q <= step_up;
        end
    end

    assign pos          = pos_q;
    assign carry        = carry_q;
    assign carry_dir_up = carry_up_q;

    AST_POS_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + POS_W'(1)) || (pos_q == $past(pos_q) - POS_W'(1))); // R2
    AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |-> (carry_up_q ? (pos_q == '0) : (pos_q == '1))); // R10
    AST_CARRY_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |=> !carry_q); // R4
endmodule

// File: rtl/qpc_read_port.sv
// Snapshot register and byte-wide read port. The snapshot follows the
// counter on falling edges until a high-byte read freezes it; it resumes
// after the low byte has been read and the strobe released.
// Assumes the host reads the high byte before the low byte.
module qpc_read_port
    import qpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pos_t              pos,
    input  logic              lo_byte_sel,
    input  logic              rd_en_n,
    output logic [BYTE_W-1:0] data,
    output logic              valid
);
    pos_t snap_q;
    logic inhibit_q;
    logic low_done_q;
    logic start_rd;

    assign start_rd = !lo_byte_sel && !rd_en_n;

    // Follow the counter while not frozen.
    always_ff @(negedge clk) begin
        if (!rst_n)          snap_q <= '0;
        else if (!inhibit_q) snap_q <= pos;
    end

    // Freeze on read start, release after the low byte is done.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            inhibit_q  <= 1'b0;
            low_done_q <= 1'b0;
        end else if (!inhibit_q) begin
            inhibit_q  <= start_rd;
            low_done_q <= 1'b0;
        end else if (low_done_q && rd_en_n) begin
            inhibit_q  <= 1'b0;
            low_done_q <= 1'b0;
        end else if (!rd_en_n && lo_byte_sel) begin
            low_done_q <= 1'b1;
        end
    end

    // Byte selection onto a bus that idles at zero.
    always_comb begin
        if (rd_en_n)          data = '0;
        else if (lo_byte_sel) data = snap_q[BYTE_W-1:0];
        else                  data = snap_q[POS_W-1 -: BYTE_W];
    end

    assign valid = !rd_en_n;

    AST_SNAP_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
        $past(inhibit_q) |-> $stable(snap_q)); // R5
    AST_SNAP_TRACK: assert property (@(negedge clk) disable iff (!rst_n)
        !$past(inhibit_q) |-> (snap_q == $past(pos))); // R8
endmodule

// File: rtl/quad_pos_counter.sv
// Top level: two phase filters, 4x decoder, position counter with wrap
// pulse, and a frozen two-byte read port.
// Assumes asynchronous phase inputs and a host that reads high byte first.
module quad_pos_counter
    import qpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_a,
    input  logic              phase_b,
    input  logic              lo_byte_sel,
    input  logic              rd_en_n,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_valid,
    output logic              carry_pulse,
    output logic              carry_up,
    output logic              decode_err
);
    localparam int unsigned N_PH = 2;

    logic [N_PH-1:0] raw_ph;
    logic [N_PH-1:0] clean_ph;
    logic            step;
    logic            step_up;
    pos_t            pos;

    assign raw_ph = {phase_a, phase_b};

    for (genvar g = 0; g < N_PH; g++) begin : g_filt
        qpc_input_filter #(.SYNC_N(2), .FILT_HOLD(3)) i_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_in    (raw_ph[g]),
            .clean_out (clean_ph[g])
        );
    end

    qpc_quad_decode i_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph_a    (clean_ph[1]),
        .ph_b    (clean_ph[0]),
        .step    (step),
        .step_up (step_up),
        .err     (decode_err)
    );

    qpc_pos_counter i_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .step         (step),
        .step_up      (step_up),
        .pos          (pos),
        .carry        (carry_pulse),
        .carry_dir_up (carry_up)
    );

    qpc_read_port i_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .pos         (pos),
        .lo_byte_sel (lo_byte_sel),
        .rd_en_n     (rd_en_n),
        .data        (data_out),
        .valid       (data_valid)
    );
endmodule

// File: tb/test_quad_pos_counter.sv
`timescale 1ns/1ps
module test_quad_pos_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase_a = 1'b0;
    logic       phase_b = 1'b0;
    logic       lo_byte_sel = 1'b1;
    logic       rd_en_n = 1'b1;
    logic [7:0] data_out;
    logic       data_valid;
    logic       carry_pulse;
    logic       carry_up;
    logic       decode_err;

    int n_chk = 0;
    int n_fail = 0;
    int n_up = 0;
    int n_dn = 0;
    logic       last_up = 1'b0;
    logic [7:0] ext_cnt = 8'h00;
    logic [1:0] ph_idx = 2'd0;

    // {a,b, expected position} after each phase move, starting from reset
    localparam logic [17:0] VEC_TAB [10] = '{
        {2'b10, 16'h0001}, {2'b11, 16'h0002}, {2'b01, 16'h0003}, {2'b00, 16'h0004},
        {2'b01, 16'h0003}, {2'b11, 16'h0002}, {2'b10, 16'h0001}, {2'b00, 16'h0000},
        {2'b01, 16'hFFFF}, {2'b00, 16'h0000}
    };

    always #2.5 clk = ~clk;

    quad_pos_counter i_quad_pos_counter (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .lo_byte_sel(lo_byte_sel), .rd_en_n(rd_en_n), .data_out(data_out),
        .data_valid(data_valid), .carry_pulse(carry_pulse), .carry_up(carry_up),
        .decode_err(decode_err)
    );

    // Extension counter model driven by the carry pulse.
    always begin
        @(posedge clk); #1;
        if (rst_n && carry_pulse) begin
            last_up = carry_up;
            if (carry_up) begin n_up++; ext_cnt = ext_cnt + 8'd1; end
            else          begin n_dn++; ext_cnt = ext_cnt - 8'd1; end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_ph(input logic [1:0] ab);
        phase_a = ab[1];
        phase_b = ab[0];
        ph_idx  = {ab[0], ab[1] ^ ab[0]};
    endtask

    task automatic step_dir(input bit up);
        logic [1:0] nx;
        logic [1:0] ab;
        nx = up ? ph_idx + 2'd1 : ph_idx - 2'd1;
        ab = {nx[1] ^ nx[0], nx[1]};
        set_ph(ab);
        cyc(10);
    endtask

    task automatic do_reset();
        set_ph(2'b00);
        lo_byte_sel = 1'b1;
        rd_en_n = 1'b1;
        rst_n = 1'b0;
        cyc(6);
        rst_n = 1'b1;
        n_up = 0; n_dn = 0; ext_cnt = 8'h00;
        cyc(2);
    endtask

    task automatic read_pos(output logic [15:0] v);
        lo_byte_sel = 1'b0; rd_en_n = 1'b0;
        cyc(2);
        chk(data_valid === 1'b1, "R6 valid high byte", data_valid, 1);
        v[15:8] = data_out;
        lo_byte_sel = 1'b1;
        cyc(1);
        chk(data_valid === 1'b1, "R6 valid low byte", data_valid, 1);
        v[7:0] = data_out;
        rd_en_n = 1'b1;
        cyc(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  hb;
        logic [7:0]  lb;

        // Reset state
        do_reset();
        chk(data_out === 8'h00 && data_valid === 1'b0, "R7 idle bus", {data_valid, data_out}, 0);
        chk(carry_pulse === 1'b0 && decode_err === 1'b0, "R9 flags after reset", {carry_pulse, decode_err}, 0);
        read_pos(v);
        chk(v === 16'h0000, "R9 position after reset", v, 0);

        // Table walk: 4x decoding in both directions, including both wraps
        for (int i = 0; i < 10; i++) begin
            set_ph(VEC_TAB[i][17:16]);
            cyc(10);
            read_pos(v);
            chk(v === VEC_TAB[i][15:0], "R2 table position", v, VEC_TAB[i][15:0]);
        end
        chk(n_up == 1 && n_dn == 1, "R4 carry count in table", {n_up[15:0], n_dn[15:0]}, 32'h0001_0001);

        // R1: 2-cycle glitch is rejected
        phase_a = 1'b1;
        cyc(2);
        phase_a = 1'b0;
        cyc(12);
        read_pos(v);
        chk(v === 16'h0000, "R1 glitch ignored", v, 0);
        chk(decode_err === 1'b0, "R1 glitch no error", decode_err, 0);

        // R3: double transition gives no count and sticky error
        set_ph(2'b11);
        cyc(12);
        read_pos(v);
        chk(v === 16'h0000, "R3 no count on double change", v, 0);
        chk(decode_err === 1'b1, "R3 error set", decode_err, 1);
        set_ph(2'b00);
        cyc(12);
        set_ph(2'b10);
        cyc(12);
        set_ph(2'b00);
        cyc(12);
        chk(decode_err === 1'b1, "R3 error sticky", decode_err, 1);
        do_reset();
        chk(decode_err === 1'b0, "R9 error cleared by reset", decode_err, 0);

        // R5/R6/R8: coherent read across 0x00FF -> 0x0100
        for (int i = 0; i < 255; i++) step_dir(1'b1);
        read_pos(v);
        chk(v === 16'h00FF, "R6 byte order", v, 16'h00FF);
        lo_byte_sel = 1'b0; rd_en_n = 1'b0;
        cyc(2);
        hb = data_out;
        chk(hb === 8'h00, "R6 high byte", hb, 0);
        rd_en_n = 1'b1;
        cyc(1);
        chk(data_out === 8'h00 && data_valid === 1'b0, "R7 bus idle mid read", {data_valid, data_out}, 0);
        step_dir(1'b1);
        lo_byte_sel = 1'b1; rd_en_n = 1'b0;
        cyc(2);
        lb = data_out;
        chk(lb === 8'hFF, "R5 low byte from frozen snapshot", lb, 8'hFF);
        rd_en_n = 1'b1;
        cyc(3);
        read_pos(v);
        chk(v === 16'h0100, "R8 snapshot released", v, 16'h0100);

        // Read straddling a 0xFFFF -> 0x0000 wrap
        do_reset();
        step_dir(1'b0);
        chk(n_dn == 1 && last_up === 1'b0, "R4 down wrap carry", {n_dn[7:0], last_up}, 9'h002);
        lo_byte_sel = 1'b0; rd_en_n = 1'b0;
        cyc(2);
        hb = data_out;
        rd_en_n = 1'b1;
        step_dir(1'b1);
        chk(n_up == 1 && last_up === 1'b1, "R4 up wrap carry", {n_up[7:0], last_up}, 9'h003);
        lo_byte_sel = 1'b1; rd_en_n = 1'b0;
        cyc(2);
        lb = data_out;
        rd_en_n = 1'b1;
        cyc(3);
        chk({hb, lb} === 16'hFFFF, "R5 coherent read across wrap", {hb, lb}, 16'hFFFF);
        read_pos(v);
        chk(v === 16'h0000, "R8 tracking after wrap read", v, 0);

        // R10: read started in the carry cycle returns the wrapped count
        do_reset();
        step_dir(1'b0);
        set_ph(2'b00);
        do begin
            @(posedge clk); #1;
        end while (carry_pulse !== 1'b1);
        lo_byte_sel = 1'b0; rd_en_n = 1'b0;
        cyc(2);
        hb = data_out;
        lo_byte_sel = 1'b1;
        cyc(1);
        lb = data_out;
        rd_en_n = 1'b1;
        cyc(3);
        chk({ext_cnt, hb, lb} === 24'h00_0000, "R10 read in carry cycle", {ext_cnt, hb, lb}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule